// File: doc/BRIEF.md
# Set/Clear Interrupt Register Bank

This block is a small memory-mapped interrupt unit for three event sources: a ready event, a timeout event and a next-word event, all produced by a flash write/erase sequencer. Each source has one enable bit and one pending bit. Software reaches each of these two bit sets through two word addresses. Writing ones to the first address turns the selected bits on. Writing ones to the second address turns them off. A zero data bit leaves its state bit unchanged, so no read-modify-write is needed. Both addresses of a pair read back the same current state.

Hardware set pulses from the sequencer make sources pending. Software can also force a source pending, for example to test the interrupt path. A read-only word gives the pending AND enabled value for each bit. The single interrupt line is a registered OR of that masked word. The block sits behind a bus front end that supplies a one-cycle write strobe, a read strobe, a byte address and write data.

Top module: `irq_bank`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, and `irq` is 0.
- R2: A write to offset 0x00 sets each enable bit whose data bit is 1 (bit 0 ready, bit 1 timeout, bit 2 next-word) and leaves the others unchanged. A read of 0x00 returns the enable bits in bits 2:0.
- R3: A write to offset 0x04 clears each enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x04 returns the same enable bits as 0x00.
- R4: A write to offset 0x08 makes pending each source whose data bit is 1, and a data bit of 0 has no effect. A read of 0x08 returns the raw pending bits in bits 2:0.
- R5: A write to offset 0x0C clears the pending bit of each source whose data bit is 1, and a data bit of 0 has no effect. A read of 0x0C returns the same raw pending bits as 0x08.
- R6: A read of offset 0x10 returns pending AND enabled in bits 2:0. A write to 0x10 changes no state.
- R7: Bits 31:3 of every readable word read as 0, and writes to those bits have no effect.
- R8: A 1 on `hw_set[i]` in a cycle makes source i pending from the next cycle on.
- R9: If `hw_set[i]` and a software clear of pending bit i fall in the same cycle, bit i is pending afterwards.
- R10: `irq` equals, one cycle later, the OR of the three masked-status bits.
- R11: A read of any other offset returns 0. A write to any other offset changes no state. `rdata` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| addr | input | AW (8) | Byte offset of the access |
| wdata | input | DW (32) | Write data |
| hw_set | input | NSRC (3) | Per-source hardware set pulses from the sequencer |
| rdata | output | DW (32) | Read data, combinational from `addr` |
| irq | output | 1 | Registered interrupt line |

## Verification
The critical collision is a hardware set pulse landing in the same cycle as a software write to the clear-status address on the same bit. The hardware set must win, and no event may be lost. A directed case drives both onto bit 0 on one edge. The random phase also mixes random `hw_set` values with random writes to every offset, so this collision recurs on all bits. Each outcome is judged by reading the raw pending word and checking `irq` in the following cycles against a bench model that applies clear, then set, then hardware set.

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NSRC = 3,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] hw_set,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam int PAD = DW - NSRC;
  localparam logic [AW-1:0] OFS_SEN = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CEN = AW'(8'h04);
  localparam logic [AW-1:0] OFS_SST = AW'(8'h08);
  localparam logic [AW-1:0] OFS_CST = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_MSK = AW'(8'h10);

  logic [NSRC-1:0] en_q, pend_q, masked, wbits;
  logic [NSRC-1:0] sen_m, cen_m, sst_m, cst_m;
  logic            irq_q;

  assign wbits = wdata[NSRC-1:0];
  assign sen_m = (wr_en && addr == OFS_SEN) ? wbits : '0;
  assign cen_m = (wr_en && addr == OFS_CEN) ? wbits : '0;
  assign sst_m = (wr_en && addr == OFS_SST) ? wbits : '0;
  assign cst_m = (wr_en && addr == OFS_CST) ? wbits : '0;
  assign masked = pend_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= (en_q | sen_m) & ~cen_m;
      pend_q <= (pend_q & ~cst_m) | sst_m | hw_set;
      irq_q  <= |masked;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_SEN, OFS_CEN: rdata = {{PAD{1'b0}}, en_q};
        OFS_SST, OFS_CST: rdata = {{PAD{1'b0}}, pend_q};
        OFS_MSK:          rdata = {{PAD{1'b0}}, masked};
        default:          rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int NSRC = 3,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [NSRC-1:0] hw_set,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] pend,
  input logic            irq
);
  localparam logic [AW-1:0] A_SEN = AW'(8'h00);
  localparam logic [AW-1:0] A_CEN = AW'(8'h04);
  localparam logic [AW-1:0] A_SST = AW'(8'h08);
  localparam logic [AW-1:0] A_CST = AW'(8'h0C);

  AST_SET_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEN) |=> ((en & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R2
  AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CEN) |=> ((en & $past(wdata[NSRC-1:0])) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_SEN || addr == A_CEN)) |=> $stable(en)); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (addr == A_SST || addr == A_CST)) && hw_set == '0) |=> $stable(pend)); // R11
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SST) |=> ((pend & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R4
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set))); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & en)))); // R10
endmodule

bind irq_bank irq_bank_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .hw_set(hw_set), .en(en_q), .pend(pend_q), .irq(irq)
);

// File: tb/test_irq_bank.sv
`timescale 1ns/1ps
module test_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  hw_set = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [2:0] en_m = '0, pend_m = '0;
  logic       irq_m = 1'b0;

  always #2.5 clk = ~clk;

  irq_bank i_irq_bank (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .hw_set(hw_set), .rdata(rdata), .irq(irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      en_m <= '0; pend_m <= '0; irq_m <= 1'b0;
    end else begin
      logic [2:0] w;
      logic [2:0] p;
      w = wdata[2:0];
      p = pend_m;
      irq_m <= |(pend_m & en_m);
      if (wr_en && addr == 8'h00) en_m <= en_m | w;
      if (wr_en && addr == 8'h04) en_m <= en_m & ~w;
      if (wr_en && addr == 8'h0C) p = p & ~w;
      if (wr_en && addr == 8'h08) p = p | w;
      pend_m <= p | hw_set;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return {29'd0, en_m};
      8'h08, 8'h0C: return {29'd0, pend_m};
      8'h10:        return {29'd0, pend_m & en_m};
      default:      return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] hw);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d; hw_set = hw;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b0; hw_set = '0; rd_en = 1'b1; addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
    chk({tag, " irq R10"}, {31'd0, irq}, {31'd0, irq_m});
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, "R1 enable");
    rd(8'h08, "R1 pending");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 set-enable, zeros leave unchanged
    wr(8'h00, 32'h5, 3'b0);  rd(8'h00, "R2 set 101");
    chk("R2 direct", rdata, 32'h5);
    wr(8'h00, 32'h2, 3'b0);  rd(8'h00, "R2 add 010");
    chk("R2 direct2", rdata, 32'h7);
    // R3 clear-enable and alias read
    wr(8'h04, 32'h1, 3'b0);  rd(8'h04, "R3 clear bit0");
    chk("R3 direct", rdata, 32'h6);
    // R4 set-status, write 0 no effect
    wr(8'h08, 32'h0, 3'b0);  rd(8'h08, "R4 write zero");
    wr(8'h08, 32'h4, 3'b0);  rd(8'h0C, "R4 set bit2");
    chk("R4 direct", rdata, 32'h4);
    // R10 irq lags masked by one cycle
    rd(8'h10, "R6 masked");
    chk("R10 irq up", {31'd0, irq}, 32'd1);
    // R5 clear-status
    wr(8'h0C, 32'h4, 3'b0);  rd(8'h08, "R5 clear bit2");
    chk("R5 direct", rdata, 32'h0);
    chk("R10 irq still up", {31'd0, irq}, 32'd1);
    rd(8'h08, "R10 irq drops");
    chk("R10 irq down", {31'd0, irq}, 32'd0);
    // R6 writes to masked ignored
    wr(8'h10, 32'hFFFF_FFFF, 3'b0); rd(8'h00, "R6 en after masked wr");
    rd(8'h08, "R6 pend after masked wr");
    // R7 upper bits
    wr(8'h00, 32'hFFFF_FFF8, 3'b0); rd(8'h00, "R7 upper set-enable");
    chk("R7 direct", rdata, 32'h6);
    wr(8'h08, 32'hFFFF_FFF8, 3'b0); rd(8'h08, "R7 upper set-status");
    // R8 hardware set
    wr(8'h20, 32'h0, 3'b010); rd(8'h08, "R8 hw set bit1");
    chk("R8 direct", rdata, 32'h2);
    // R9 hw set beats sw clear
    wr(8'h0C, 32'h7, 3'b001); rd(8'h08, "R9 conflict");
    chk("R9 direct", rdata, 32'h1);
    // R11 unmapped
    wr(8'h14, 32'h7, 3'b0); rd(8'h14, "R11 unmapped read");
    rd(8'h00, "R11 en after unmapped wr");
    rd(8'h08, "R11 pend after unmapped wr");
    @(negedge clk); wr_en = 0; hw_set = 0; rd_en = 0; addr = 8'h00; #1;
    chk("R11 rd_en low", rdata, 32'd0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [7:0] ra;
      a  = 8'(($urandom % 7) * 4);
      ra = 8'(($urandom % 6) * 4);
      wr(a, $urandom, (($urandom % 4) == 0) ? 3'($urandom) : 3'b0);
      rd(ra, "R9 random mix");
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule